// File: doc/BRIEF.md
# Vertical Transfer Clock Pattern Generator

This block produces the four phase clocks that move charge one line at a time down the vertical registers of an image sensor. It stores four independent waveform patterns. Every pattern has its own repetition period in pixel clocks and its own repetition count. For each of the four phase outputs, a pattern also holds a starting level and two toggle offsets inside the period. A line-start strobe restarts the pixel position and picks, from the pattern-select input, which stored pattern drives all four phase outputs for that line.

The pattern runs its period the programmed number of times. After that, every phase goes back to its starting level and stays there until the next strobe. A repetition count of zero gives a static line, with each phase held at its starting level. The patterns are loaded through a plain address/data/write-enable port, and writes take effect at the next clock edge.

Top module: `vclk_pattern_gen`

## Requirements
- R1: After reset all pattern settings are zero and every phase output is low. No phase toggles until the first line-start strobe.
- R2: A write sets the field picked by `wr_addr = {pattern[1:0], field[2:0]}`. Field 0 is the period length in `wr_data[11:0]`. Field 1 is the repetition count in `wr_data[7:0]`. Fields 4 to 7 are the settings of phases 0 to 3: toggle A in `wr_data[11:0]`, toggle B in `wr_data[23:12]` and the starting level in `wr_data[24]`. Fields 2 and 3 store nothing.
- R3: A line-start strobe sampled at a clock edge resets the position to offset 0 of repetition 0. From that edge on, the outputs show the offset-0 levels, even when the strobe arrives in the middle of a line.
- R4: The pattern select is captured only with the line-start strobe. Changes to the select during a line have no effect on the outputs.
- R5: While a pattern runs, each phase equals its starting level XOR (offset >= toggle A) XOR (offset >= toggle B). The offset advances by one per clock. Equal toggle positions therefore cancel.
- R6: The offset wraps to 0 after reaching length-1, so the waveform repeats with a period of `length` clocks.
- R7: A repetition count of N gives exactly N periods. The phases then hold their starting levels until the next strobe.
- R8: A repetition count of 0 keeps every phase at its starting level for the whole line.
- R9: A toggle position equal to or greater than the pattern length never inverts the phase.
- R10: A write to the running pattern changes the outputs from the next edge on. A write to any other pattern leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Pattern index and field code |
| wr_data | input | 25 | Write data |
| line_start | input | 1 | Line-start strobe, one clock wide |
| pat_sel | input | 2 | Pattern to capture at the next line start |
| vphase | output | 4 | Vertical phase clocks, bit k is phase k |

## Verification
Every result shows up one edge after the stimulus that causes it. The phase outputs are decoded combinationally from registered position and settings, so a strobe, a counter step or a register write at edge k is visible during the cycle that follows edge k. The bench drives inputs on falling edges. A behavioural model advances on the same rising edge, using an absolute clock count since the strobe, and the outputs are compared with it on every falling edge. No check waits extra cycles or samples at the edge.

// File: rtl/vpg_pkg.sv
package vpg_pkg;
  // Field codes inside one pattern's address window.
  typedef enum logic [2:0] {
    FLD_LEN   = 3'd0,
    FLD_REP   = 3'd1,
    FLD_SPARE = 3'd2,
    FLD_SPR2  = 3'd3,
    FLD_PH0   = 3'd4,
    FLD_PH1   = 3'd5,
    FLD_PH2   = 3'd6,
    FLD_PH3   = 3'd7
  } vpg_field_e;

  localparam int unsigned FLD_W = 3;
endpackage

// File: rtl/vpg_cfg_regs.sv
module vpg_cfg_regs
  import vpg_pkg::*;
#(
  parameter int unsigned NUM_PAT = 4,
  parameter int unsigned NUM_PH  = 4,
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned REP_W   = 8,
  localparam int unsigned PAT_W  = $clog2(NUM_PAT),
  localparam int unsigned ADDR_W = PAT_W + FLD_W,
  localparam int unsigned DATA_W = 2 * CNT_W + 1
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      wr_en,
  input  logic [ADDR_W-1:0]                         wr_addr,
  input  logic [DATA_W-1:0]                         wr_data,
  output logic [NUM_PAT-1:0][CNT_W-1:0]             len_o,
  output logic [NUM_PAT-1:0][REP_W-1:0]             rep_o,
  output logic [NUM_PAT-1:0][NUM_PH-1:0][CNT_W-1:0] tog_a_o,
  output logic [NUM_PAT-1:0][NUM_PH-1:0][CNT_W-1:0] tog_b_o,
  output logic [NUM_PAT-1:0][NUM_PH-1:0]            start_o
);

  logic [FLD_W-1:0] fld;
  logic [PAT_W-1:0] pat;

  assign fld = wr_addr[FLD_W-1:0];
  assign pat = wr_addr[ADDR_W-1:FLD_W];

  for (genvar g = 0; g < NUM_PAT; g++) begin : g_pat
    logic             sel_hit;
    logic             len_en;
    logic             rep_en;
    logic [CNT_W-1:0] len_r;
    logic [REP_W-1:0] rep_r;

    assign sel_hit = wr_en && (pat == PAT_W'(g));
    assign len_en  = sel_hit && (fld == FLD_LEN);
    assign rep_en  = sel_hit && (fld == FLD_REP);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        len_r <= '0;
        rep_r <= '0;
      end else begin
        if (len_en) len_r <= wr_data[CNT_W-1:0];
        if (rep_en) rep_r <= wr_data[REP_W-1:0];
      end
    end

    assign len_o[g] = len_r;
    assign rep_o[g] = rep_r;

    for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
      logic             ph_en;
      logic [CNT_W-1:0] ta_r;
      logic [CNT_W-1:0] tb_r;
      logic             st_r;

      assign ph_en = sel_hit && (fld == FLD_W'(NUM_PH + p));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ta_r <= '0;
          tb_r <= '0;
          st_r <= 1'b0;
        end else if (ph_en) begin
          ta_r <= wr_data[CNT_W-1:0];
          tb_r <= wr_data[2*CNT_W-1:CNT_W];
          st_r <= wr_data[2*CNT_W];
        end
      end

      assign tog_a_o[g][p] = ta_r;
      assign tog_b_o[g][p] = tb_r;
      assign start_o[g][p] = st_r;
    end
  end

endmodule

// File: rtl/vpg_line_timer.sv
module vpg_line_timer #(
  parameter int unsigned NUM_PAT = 4,
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned REP_W   = 8,
  localparam int unsigned PAT_W  = $clog2(NUM_PAT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic [PAT_W-1:0] pat_sel,
  input  logic [CNT_W-1:0] cur_len,
  input  logic [REP_W-1:0] cur_rep,
  output logic [CNT_W-1:0] pix_o,
  output logic [REP_W-1:0] rep_idx_o,
  output logic             done_o,
  output logic [PAT_W-1:0] sel_o
);

  logic [CNT_W-1:0] pix_q, pix_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic             done_q, done_d;
  logic [PAT_W-1:0] sel_q, sel_d;
  logic             run;
  logic             wrap;
  logic             last_rep;

  assign run      = !done_q && (cur_rep != '0);
  assign wrap     = (pix_q == cur_len - CNT_W'(1));
  assign last_rep = (rep_q == cur_rep - REP_W'(1));

  always_comb begin
    pix_d  = pix_q;
    rep_d  = rep_q;
    done_d = done_q;
    sel_d  = sel_q;
    if (line_start) begin
      pix_d  = '0;
      rep_d  = '0;
      done_d = 1'b0;
      sel_d  = pat_sel;
    end else if (run) begin
      if (wrap) begin
        pix_d = '0;
        if (last_rep) done_d = 1'b1;
        else          rep_d  = rep_q + REP_W'(1);
      end else begin
        pix_d = pix_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q  <= '0;
      rep_q  <= '0;
      done_q <= 1'b1;
      sel_q  <= '0;
    end else begin
      pix_q  <= pix_d;
      rep_q  <= rep_d;
      done_q <= done_d;
      sel_q  <= sel_d;
    end
  end

  assign pix_o     = pix_q;
  assign rep_idx_o = rep_q;
  assign done_o    = done_q;
  assign sel_o     = sel_q;

endmodule

// File: rtl/vpg_phase_shaper.sv
module vpg_phase_shaper #(
  parameter int unsigned CNT_W = 12
) (
  input  logic [CNT_W-1:0] pix,
  input  logic [CNT_W-1:0] len,
  input  logic [CNT_W-1:0] tog_a,
  input  logic [CNT_W-1:0] tog_b,
  input  logic             start_lvl,
  input  logic             hold,
  output logic             lvl
);

  logic a_passed;
  logic b_passed;

  always_comb begin
    a_passed = (tog_a < len) && (pix >= tog_a);
    b_passed = (tog_b < len) && (pix >= tog_b);
    if (hold) lvl = start_lvl;
    else      lvl = start_lvl ^ a_passed ^ b_passed;
  end

endmodule

// File: rtl/vclk_pattern_gen.sv
module vclk_pattern_gen
  import vpg_pkg::*;
#(
  parameter int unsigned NUM_PAT = 4,
  parameter int unsigned NUM_PH  = 4,
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned REP_W   = 8,
  localparam int unsigned PAT_W  = $clog2(NUM_PAT),
  localparam int unsigned ADDR_W = PAT_W + FLD_W,
  localparam int unsigned DATA_W = 2 * CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              line_start,
  input  logic [PAT_W-1:0]  pat_sel,
  output logic [NUM_PH-1:0] vphase
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [NUM_PAT-1:0][CNT_W-1:0]             len_all;
  logic [NUM_PAT-1:0][REP_W-1:0]             rep_all;
  logic [NUM_PAT-1:0][NUM_PH-1:0][CNT_W-1:0] tog_a_all;
  logic [NUM_PAT-1:0][NUM_PH-1:0][CNT_W-1:0] tog_b_all;
  logic [NUM_PAT-1:0][NUM_PH-1:0]            start_all;

  vpg_cfg_regs #(
    .NUM_PAT(NUM_PAT), .NUM_PH(NUM_PH), .CNT_W(CNT_W), .REP_W(REP_W)
  ) cfg_i (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .len_o   (len_all),
    .rep_o   (rep_all),
    .tog_a_o (tog_a_all),
    .tog_b_o (tog_b_all),
    .start_o (start_all)
  );

  logic [CNT_W-1:0] pix;
  logic [REP_W-1:0] rep_idx;
  logic             done;
  logic [PAT_W-1:0] sel_q;
  logic [CNT_W-1:0] cur_len;
  logic [REP_W-1:0] cur_rep;
  logic [NUM_PH-1:0] cur_start;
  logic             hold;

  assign cur_len   = len_all[sel_q];
  assign cur_rep   = rep_all[sel_q];
  assign cur_start = start_all[sel_q];
  assign hold      = done || (cur_rep == '0);

  vpg_line_timer #(
    .NUM_PAT(NUM_PAT), .CNT_W(CNT_W), .REP_W(REP_W)
  ) timer_i (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .line_start (line_start),
    .pat_sel    (pat_sel),
    .cur_len    (cur_len),
    .cur_rep    (cur_rep),
    .pix_o      (pix),
    .rep_idx_o  (rep_idx),
    .done_o     (done),
    .sel_o      (sel_q)
  );

  for (genvar p = 0; p < NUM_PH; p++) begin : g_shape
    vpg_phase_shaper #(.CNT_W(CNT_W)) shaper_i (
      .pix       (pix),
      .len       (cur_len),
      .tog_a     (tog_a_all[sel_q][p]),
      .tog_b     (tog_b_all[sel_q][p]),
      .start_lvl (cur_start[p]),
      .hold      (hold),
      .lvl       (vphase[p])
    );
  end

endmodule

// File: rtl/vpg_checker.sv
module vpg_checker #(
  parameter int unsigned NUM_PAT = 4,
  parameter int unsigned NUM_PH  = 4,
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned REP_W   = 8,
  localparam int unsigned PAT_W  = $clog2(NUM_PAT)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_start,
  input logic [PAT_W-1:0]  pat_sel,
  input logic [CNT_W-1:0]  pix,
  input logic [REP_W-1:0]  rep_idx,
  input logic              done,
  input logic [PAT_W-1:0]  sel_q,
  input logic [CNT_W-1:0]  cur_len,
  input logic [REP_W-1:0]  cur_rep,
  input logic [NUM_PH-1:0] cur_start,
  input logic [NUM_PH-1:0] vphase
);

  a_r3_strobe_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (pix == '0) && (rep_idx == '0) && !done);

  a_r4_sel_captured: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (sel_q == $past(pat_sel)));

  a_r4_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(sel_q));

  a_r6_offset_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && !done && (cur_rep != '0) && (pix != cur_len - CNT_W'(1)))
      |=> (pix == $past(pix) + CNT_W'(1)));

  a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (vphase == cur_start));

  a_r8_static_level: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_rep == '0) |-> (vphase == cur_start));

endmodule

bind vclk_pattern_gen vpg_checker #(
  .NUM_PAT(NUM_PAT), .NUM_PH(NUM_PH), .CNT_W(CNT_W), .REP_W(REP_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .line_start (line_start),
  .pat_sel    (pat_sel),
  .pix        (pix),
  .rep_idx    (rep_idx),
  .done       (done),
  .sel_q      (sel_q),
  .cur_len    (cur_len),
  .cur_rep    (cur_rep),
  .cur_start  (cur_start),
  .vphase     (vphase)
);

// File: tb/vclk_pattern_gen_tb.sv
module vclk_pattern_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NPAT = 4;
  localparam int NPH  = 4;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [24:0] wr_data;
  logic        line_start;
  logic [1:0]  pat_sel;
  logic [3:0]  vphase;

  vclk_pattern_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .line_start(line_start), .pat_sel(pat_sel),
    .vphase(vphase)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    finished = 0;
  string req_tag  = "R1";

  // Behavioural model: absolute clock count since strobe.
  int m_len  [NPAT];
  int m_rep  [NPAT];
  int m_ta   [NPAT][NPH];
  int m_tb   [NPAT][NPH];
  bit m_st   [NPAT][NPH];
  int m_t;
  int m_sel;
  bit m_started;
  int rst_cycles;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NPAT; g++) begin
        m_len[g] = 0; m_rep[g] = 0;
        for (int p = 0; p < NPH; p++) begin
          m_ta[g][p] = 0; m_tb[g][p] = 0; m_st[g][p] = 0;
        end
      end
      m_t = 0; m_sel = 0; m_started = 0; rst_cycles = 0;
    end else begin
      if (rst_cycles < 2) rst_cycles++;
      else begin
        if (line_start) begin
          m_t = 0; m_started = 1; m_sel = int'(pat_sel);
        end else if (m_started) m_t++;
        if (wr_en) begin
          int g, f;
          g = int'(wr_addr[4:3]);
          f = int'(wr_addr[2:0]);
          if (f == 0) m_len[g] = int'(wr_data[11:0]);
          else if (f == 1) m_rep[g] = int'(wr_data[7:0]);
          else if (f >= 4) begin
            m_ta[g][f-4] = int'(wr_data[11:0]);
            m_tb[g][f-4] = int'(wr_data[23:12]);
            m_st[g][f-4] = wr_data[24];
          end
        end
      end
    end
  end

  function automatic logic [3:0] model_out();
    logic [3:0] r;
    int L, off;
    L = (m_len[m_sel] == 0) ? 4096 : m_len[m_sel];
    for (int p = 0; p < NPH; p++) begin
      r[p] = m_st[m_sel][p];
      if (m_started && m_rep[m_sel] != 0 && m_t < m_rep[m_sel] * L) begin
        off = m_t % L;
        if (m_ta[m_sel][p] < m_len[m_sel] && off >= m_ta[m_sel][p]) r[p] = ~r[p];
        if (m_tb[m_sel][p] < m_len[m_sel] && off >= m_tb[m_sel][p]) r[p] = ~r[p];
      end
    end
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [3:0] e;
      e = model_out();
      n_checks++;
      if (vphase !== e) begin
        n_errors++;
        $display("FAIL %s t=%0t vphase actual=%b expected=%b", req_tag, $time, vphase, e);
      end
    end
  end

  task automatic wr(input int g, input int f, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {2'(g), 3'(f)}; wr_data = 25'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_ph(input int g, input int p, input bit st, input int a, input int b);
    wr(g, 4 + p, (int'(st) << 24) | (b << 12) | a);
  endtask

  task automatic strobe(input int s);
    @(negedge clk);
    line_start = 1'b1; pat_sel = 2'(s);
    @(negedge clk);
    line_start = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    line_start = 1'b0; pat_sel = '0;
    #(CLK_PERIOD * 3);
    // R1: outputs low while reset is held
    n_checks++;
    if (vphase !== 4'b0000) begin
      n_errors++;
      $display("FAIL R1 reset actual=%b expected=0000", vphase);
    end
    @(negedge clk); rst_n = 1'b1;
    req_tag = "R1"; run(6);

    // R2: program pattern 0 (len 8, two periods) incl. ignored and coincident toggles
    req_tag = "R2";
    wr(0, 0, 8); wr(0, 1, 2);
    wr_ph(0, 0, 0, 2, 5);
    wr_ph(0, 1, 1, 0, 4);
    wr_ph(0, 2, 0, 3, 9);
    wr_ph(0, 3, 1, 7, 7);
    wr(0, 2, 32'h1FFFFFF); wr(0, 3, 32'h0ABCDEF);
    req_tag = "R1"; run(3);
    req_tag = "R5"; strobe(0); run(8);
    req_tag = "R6"; run(8);
    req_tag = "R7"; run(10);
    req_tag = "R9"; strobe(0); run(17);

    // R7: single period
    req_tag = "R2";
    wr(1, 0, 5); wr(1, 1, 1);
    wr_ph(1, 0, 1, 1, 3); wr_ph(1, 1, 0, 4, 2);
    wr_ph(1, 2, 1, 0, 5); wr_ph(1, 3, 0, 2, 2);
    req_tag = "R7"; strobe(1); run(12);

    // R8: zero repetitions
    req_tag = "R2";
    wr(2, 0, 6); wr(2, 1, 0);
    wr_ph(2, 0, 1, 1, 2); wr_ph(2, 1, 0, 1, 2);
    wr_ph(2, 2, 1, 0, 3); wr_ph(2, 3, 0, 2, 4);
    req_tag = "R8"; strobe(2); run(14);

    // R4: select change without strobe has no effect
    req_tag = "R2";
    wr(3, 0, 3); wr(3, 1, 4);
    wr_ph(3, 0, 0, 1, 2); wr_ph(3, 1, 1, 2, 3);
    wr_ph(3, 2, 0, 0, 1); wr_ph(3, 3, 1, 1, 1);
    req_tag = "R4"; strobe(3); run(3);
    @(negedge clk); pat_sel = 2'd1;
    run(12);

    // R3: strobe in the middle of a repetition
    req_tag = "R3"; strobe(0); run(5);
    strobe(1); run(2); strobe(0); run(20);

    // R10: writes to other pattern ignored, to running pattern immediate
    req_tag = "R10"; strobe(0); run(3);
    wr(1, 0, 2); wr_ph(1, 0, 0, 1, 1); wr(2, 1, 7);
    wr_ph(0, 0, 1, 3, 6);
    run(12);

    // R7: long count, then hold
    req_tag = "R7";
    wr(3, 0, 2); wr(3, 1, 200);
    strobe(3); run(420);

    req_tag = "R1";
    run(2);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule